// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Core

This block is an on-chip synchronous memory that moves every access as a pair of data words. A read strobe and a write strobe each start a two-beat burst. The caller gives one word-pair index on a shared address port. The block forces the low word-address bit to 0 for the first beat and to 1 for the second. The array therefore holds twice as many words as the external address can index: with `ADDR_W` address bits it holds 2^(ADDR_W+1) words of `DATA_W` bits.

Read data leaves on its own output bus and write data arrives on its own input bus, so read and write bursts overlap freely. The two beats of a double-data-rate transfer appear here as two consecutive cycles of a single clock. The address port is time-shared. A new burst can start on each port every second cycle, so reads and writes interleave by taking the address port on alternating cycles.

Write byte enables travel with each data beat, so each beat masks its own byte lanes. The read path is coherent with a write that has been accepted but not yet committed to the array.

Top module: `burst2_sram`

## Requirements
- R1: After reset, `rvalid` is low, and it stays low until a read is accepted.
- R2: An accepted read at index A produces exactly two valid beats on back-to-back cycles. The first beat is array word {A,0} and the second is word {A,1}, where the appended bit is the low word-address bit.
- R3: If a read strobe is sampled at the clock edge ending cycle r, its first beat is on `rdata` with `rvalid` high during cycle r+2, and its second beat during cycle r+3.
- R4: A write strobe captures the index A. The data beat in the next cycle is written to word {A,0}, and the data beat in the cycle after that is written to word {A,1}.
- R5: Bit i of `wbe`, sampled together with a beat, enables byte lane i of that beat. Lane i is bits i*BYTE_W through i*BYTE_W+BYTE_W-1. A lane whose enable is low keeps its stored value.
- R6: Read and write bursts overlap in time when their strobes fall on alternating cycles, and each port can accept a new burst every second cycle.
- R7: A read accepted in any cycle after a write strobe returns that write's data, merged byte by byte with the old contents. This holds even when the write's second beat has not yet arrived at the time of the read strobe.
- R8: A write accepted after a read strobe does not change the data returned by that read.
- R9: A strobe on a port in the cycle right after that port accepted a burst is ignored.
- R10: When the read and write strobes are both presented in a cycle where the read can be accepted, the read takes the address and the write is dropped. The memory is left unchanged by the dropped write.
- R11: In cycles with no accepted strobe, the data and byte-enable inputs have no effect on the memory, and `rvalid` is low unless a burst is still being delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one data beat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read burst strobe |
| wr_req | input | 1 | Write burst strobe |
| addr | input | ADDR_W | Word-pair index, taken by the accepted strobe |
| wdata | input | DATA_W | Write data beat |
| wbe | input | DATA_W/BYTE_W | Per-lane enables for the current write beat |
| rdata | output | DATA_W | Read data beat |
| rvalid | output | 1 | High while `rdata` carries a read beat |

## Verification
The hardest case to reach is a read whose strobe lands one cycle after a write strobe to the same index. At that point the write's first beat is held in a side register and its second beat has not been sampled yet. The stimulus creates this case by putting write strobes on even cycles and reads of the same index on odd cycles, with random byte enables. It also runs the reverse order to show that a later write stays invisible to an earlier read. A long random stream of strobes then mixes both orders with busy-cycle and same-cycle strobe collisions.

// File: rtl/burst2_sram.sv
module burst2_sram #(
  parameter int DATA_W = 18,
  parameter int BYTE_W = 9,
  parameter int ADDR_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req,
  input  logic                       wr_req,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [DATA_W/BYTE_W-1:0]   wbe,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rvalid
);
  localparam int LANES = DATA_W / BYTE_W;
  localparam int DEPTH = 2 ** (ADDR_W + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              rd_ph1, rd_ph2, wr_ph1, wr_ph2;
  logic [ADDR_W-1:0] ra, wa;
  logic [DATA_W-1:0] b0d;
  logic [LANES-1:0]  b0e;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                               input logic [DATA_W-1:0] nw,
                                               input logic [LANES-1:0]  be);
    logic [DATA_W-1:0] r;
    r = old;
    for (int i = 0; i < LANES; i++)
      if (be[i]) r[i*BYTE_W +: BYTE_W] = nw[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic rd_go, wr_go, hit;
  logic [DATA_W-1:0] word0, word1;

  assign rd_go = rd_req & ~rd_ph1;
  assign wr_go = wr_req & ~wr_ph1 & ~rd_go;
  assign hit   = wr_ph2 && (wa == ra);
  assign word0 = hit ? merge(mem[{ra, 1'b0}], b0d, b0e) : mem[{ra, 1'b0}];
  assign word1 = mem[{ra, 1'b1}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ph1 <= 1'b0;
      rd_ph2 <= 1'b0;
      wr_ph1 <= 1'b0;
      wr_ph2 <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
      ra     <= '0;
      wa     <= '0;
      b0d    <= '0;
      b0e    <= '0;
    end else begin
      rd_ph1 <= rd_go;
      rd_ph2 <= rd_ph1;
      wr_ph1 <= wr_go;
      wr_ph2 <= wr_ph1;
      if (rd_go) ra <= addr;
      if (wr_go) wa <= addr;
      if (wr_ph1) begin
        b0d <= wdata;
        b0e <= wbe;
      end
      rvalid <= rd_ph1 | rd_ph2;
      if (rd_ph1)      rdata <= word0;
      else if (rd_ph2) rdata <= word1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ph2) begin
      mem[{wa, 1'b0}] <= merge(mem[{wa, 1'b0}], b0d, b0e);
      mem[{wa, 1'b1}] <= merge(mem[{wa, 1'b1}], wdata, wbe);
    end
  end
endmodule

// File: rtl/burst2_sram_chk.sv
module burst2_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic wr_req,
  input logic rvalid,
  input logic rd_ph1,
  input logic rd_ph2,
  input logic wr_ph1
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ph1) |-> ##2 rvalid); // R3
  AST_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid); // R2
  AST_READ_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && wr_req && !rd_ph1) |=> !wr_ph1); // R10
  AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ph1 |=> !rd_ph1); // R9
  AST_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ph1 |=> !wr_ph1); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ph1 && !rd_ph2) |=> !rvalid); // R11
endmodule

bind burst2_sram burst2_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
  .rvalid(rvalid), .rd_ph1(rd_ph1), .rd_ph2(rd_ph2), .wr_ph1(wr_ph1)
);

// File: tb/burst2_sram_test.sv
module burst2_sram_test;
  localparam int CLK_P  = 10;
  localparam int DW     = 18;
  localparam int BW     = 9;
  localparam int AW     = 5;
  localparam int L      = DW / BW;
  localparam int NIDX   = 2 ** AW;
  localparam int DEPTH  = 2 ** (AW + 1);

  logic clk = 0, rst_n = 0, rd_req = 0, wr_req = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [L-1:0]  wbe = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  burst2_sram #(.DATA_W(DW), .BYTE_W(BW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
    .wdata(wdata), .wbe(wbe), .rdata(rdata), .rvalid(rvalid));

  always #(CLK_P/2) clk = ~clk;

  int n_vec = 0, n_bad = 0, wd = 0, cyc = 0;
  int last_rd = -10, last_wr = -10;
  bit done = 0;
  string cur = "R1";
  logic [DW-1:0] mem_m [DEPTH];
  int sched [int];
  int m_wa;
  logic [DW-1:0] m_d0;
  logic [L-1:0]  m_e0;

  function automatic logic [DW-1:0] lanes(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [L-1:0] e);
    logic [DW-1:0] r = o;
    for (int i = 0; i < L; i++) if (e[i]) r[i*BW +: BW] = n[i*BW +: BW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: got %h expected %h", cur, what, cyc, act, exp);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input int a, input bit full_be);
    bit ra_ok, wa_ok;
    logic [DW-1:0] d = DW'($urandom);
    logic [L-1:0]  e = full_be ? '1 : L'($urandom);
    rd_req = rd; wr_req = wr; addr = AW'(a); wdata = d; wbe = e;
    ra_ok = rd && (last_rd != cyc - 1);
    wa_ok = wr && (last_wr != cyc - 1) && !ra_ok;
    if (last_wr == cyc - 1) begin m_d0 = d; m_e0 = e; end
    if (last_wr == cyc - 2) begin
      mem_m[2*m_wa]   = lanes(mem_m[2*m_wa], m_d0, m_e0);
      mem_m[2*m_wa+1] = lanes(mem_m[2*m_wa+1], d, e);
    end
    if (ra_ok) begin
      sched[cyc+2] = 2*a;
      sched[cyc+3] = 2*a + 1;
      last_rd = cyc;
    end
    if (wa_ok) begin m_wa = a; last_wr = cyc; end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (sched.exists(cyc)) begin
      chk(rvalid === 1'b1, "rvalid", DW'(rvalid), 1);
      chk(rdata === mem_m[sched[cyc]], "rdata", rdata, mem_m[sched[cyc]]);
      sched.delete(cyc);
    end else begin
      chk(rvalid === 1'b0, "rvalid idle", DW'(rvalid), 0);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000 && !done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur = "R1";
    chk(rvalid === 1'b0, "reset rvalid", DW'(rvalid), 0);
    step(0, 0, 0, 1);
    // R4: fill every index with full-lane writes
    cur = "R4";
    for (int k = 0; k < 2*NIDX + 2; k++) step(0, (k % 2 == 0) && k < 2*NIDX, k/2, 1);
    // R11: stray data with no strobe
    cur = "R11";
    for (int k = 0; k < 6; k++) step(0, 0, k, 0);
    // R2 and R3: back-to-back reads of every index
    cur = "R2/R3";
    for (int k = 0; k < 2*NIDX + 4; k++) step((k % 2 == 0) && k < 2*NIDX, 0, k/2, 1);
    // R5: masked writes, then read back
    cur = "R5";
    for (int k = 0; k < 18; k++) step(0, (k % 2 == 0) && k < 16, k/2, 0);
    for (int k = 0; k < 20; k++) step((k % 2 == 0) && k < 16, 0, k/2, 1);
    // R9: strobes held high on both ports every cycle
    cur = "R9";
    for (int k = 0; k < 12; k++) step(1, 0, k, 1);
    for (int k = 0; k < 12; k++) step(0, 1, 3 + k, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1);
    // R10: simultaneous strobes, write must be dropped
    cur = "R10";
    for (int k = 0; k < 12; k++) step(k % 2 == 0, k % 2 == 0, (k % 2 == 0) ? 20 : 21, 0);
    for (int k = 0; k < 8; k++) step(k % 2 == 0, 0, 20 + k/2, 1);
    // R7: read one cycle after write to same index
    cur = "R7";
    for (int k = 0; k < 24; k++) step(k % 2 == 1, k % 2 == 0, 5 + k/4, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1);
    // R8: write one cycle after read to same index
    cur = "R8";
    for (int k = 0; k < 24; k++) step(k % 2 == 0, k % 2 == 1, 9 + k/4, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1);
    // R6: random overlapping traffic
    cur = "R6";
    for (int k = 0; k < 2000; k++)
      step(($urandom % 3) != 0, ($urandom % 3) != 0, int'($urandom % NIDX), ($urandom % 2) == 0);
    for (int k = 0; k < 6; k++) step(0, 0, 0, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule